// File: doc/BRIEF.md
# Local Interrupt Timer

This block is the countdown timer of a per-processor interrupt controller. Software programs two 32-bit registers: a timer entry that says what happens on expiry, and an initial count that loads and starts the countdown. The current count drops by one on each cycle in which the fixed tick enable is high. When it runs out, the block raises an interrupt request toward the local interrupt tracker.

The timer entry holds the request's vector, delivery mode and trigger mode, a mask bit that suppresses the request, and a periodic bit that picks between reloading from the initial count and stopping after one expiry. The request is a valid/ready transfer: once raised it stays up, with a stable payload, until the receiver takes it.

Register select codes on `reg_addr`: 0 is the timer entry, 1 is the initial count, 2 is the current count (read-only), and 3 reads as zero. Reads are combinational from `reg_addr`. Writes take effect at the clock edge at which `reg_wr` is high.

Top module: `lvt_timer`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, the entry reads 0x0001_0000 (masked), both counts read 0, and `req_valid` is low.
- R2: Entry fields: vector in bits 7:0, delivery mode in 10:8, status 12, polarity 13, remote flag 14, trigger mode 15, mask 16, periodic 17. Bits 11 and 31:18 read as zero and ignore writes. All other bits read back as written.
- R3: A write to select 1 sets both the initial count and the current count to the written value. Writing 0 stops the timer and raises no request.
- R4: While the current count is nonzero it drops by exactly one on each cycle with `tick_en` high, and holds when `tick_en` is low.
- R5: Expiry is a tick while the current count is 1. If the mask bit is clear, `req_valid` is high in the next cycle, carrying vector = entry[7:0], mode = entry[10:8] and level = entry[15] as they stood at expiry.
- R6: An expiry with the mask bit set raises no request. Its reload still follows the periodic bit.
- R7: With the periodic bit set, the expiry tick loads the current count with the initial count, so the countdown repeats.
- R8: With the periodic bit clear, the expiry tick leaves the current count at 0. It stays there until the next write to the initial count.
- R9: While `req_valid` is high and `req_ready` is low, the request and its payload hold. `req_valid` falls after an edge where both are high, unless a new expiry occurs at that edge. An expiry while a request is held and not accepted is merged into it, and the old payload is kept.
- R10: A write to the initial count in a tick cycle takes priority over the tick. That cycle counts no expiry and no decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable, one decrement per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 entry, 1 initial, 2 current) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| req_ready | input | 1 | Receiver accepts the request |
| req_valid | output | 1 | Interrupt request pending |
| req_vector | output | 8 | Request vector |
| req_mode | output | 3 | Request delivery mode |
| req_level | output | 1 | Request trigger mode (1 = level) |

## Verification
The countdown is run with a continuous tick, with alternating ticks and with idle stretches, so that a lost or doubled decrement shows up as a count mismatch. Expiry is driven with the four combinations of mask and periodic bits, which separates the request decision from the reload decision. The receiver is held not-ready across a second expiry to tell merging apart from overwriting. A zero write and a write that lands on the expiry tick show whether a load wins over the countdown.

// File: rtl/lvt_pkg.sv
package lvt_pkg;

    localparam int REG_W = 32;

    // Writable bits of the timer entry; 11 and 31:18 stay zero
    localparam logic [REG_W-1:0] ENTRY_WMASK = 32'h0003_F7FF;
    localparam logic [REG_W-1:0] ENTRY_RESET = 32'h0001_0000;

    typedef struct packed {
        logic [13:0] rsv_hi;
        logic        periodic;
        logic        masked;
        logic        level;
        logic        remote_flag;
        logic        polarity;
        logic        status;
        logic        rsv_11;
        logic [2:0]  mode;
        logic [7:0]  vector;
    } lvt_entry_t;

    typedef struct packed {
        logic [7:0] vector;
        logic [2:0] mode;
        logic       level;
    } lvt_req_t;

    typedef enum logic [1:0] {
        SEL_ENTRY = 2'd0,
        SEL_INIT  = 2'd1,
        SEL_CUR   = 2'd2,
        SEL_NONE  = 2'd3
    } lvt_sel_e;

    function automatic lvt_entry_t entry_clean(input logic [REG_W-1:0] d);
        return lvt_entry_t'(d & ENTRY_WMASK);
    endfunction

    function automatic lvt_req_t entry_payload(input lvt_entry_t e);
        lvt_req_t r;
        r.vector = e.vector;
        r.mode   = e.mode;
        r.level  = e.level;
        return r;
    endfunction

endpackage

// File: rtl/lvt_regs.sv
module lvt_regs
    import lvt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [1:0]       addr,
    input  logic [REG_W-1:0] wdata,
    input  logic [CNT_W-1:0] cur_cnt,
    output lvt_entry_t       entry,
    output logic [CNT_W-1:0] init_cnt,
    output logic             init_load,
    output logic [CNT_W-1:0] init_val,
    output logic [REG_W-1:0] rdata
);

    lvt_sel_e sel;
    logic [REG_W-1:0] init_ext;
    logic [REG_W-1:0] cur_ext;

    assign sel       = lvt_sel_e'(addr);
    assign init_load = wr && (sel == SEL_INIT);
    assign init_val  = wdata[CNT_W-1:0];

    generate
        if (CNT_W < REG_W) begin : g_ext
            assign init_ext = {{(REG_W-CNT_W){1'b0}}, init_cnt};
            assign cur_ext  = {{(REG_W-CNT_W){1'b0}}, cur_cnt};
        end else begin : g_full
            assign init_ext = init_cnt;
            assign cur_ext  = cur_cnt;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            entry    <= lvt_entry_t'(ENTRY_RESET);
            init_cnt <= '0;
        end else begin
            if (wr && (sel == SEL_ENTRY))
                entry <= entry_clean(wdata);
            if (init_load)
                init_cnt <= init_val;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_ENTRY: rdata = REG_W'(entry);
            SEL_INIT:  rdata = init_ext;
            SEL_CUR:   rdata = cur_ext;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/lvt_counter.sv
module lvt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             periodic,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cur,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic at_one;
    logic running;

    assign at_one  = (cur == ONE);
    assign running = (cur != '0);
    // A load in the same cycle pre-empts the tick
    assign expire  = tick_en && at_one && !load;

    always_ff @(posedge clk) begin
        if (rst)
            cur <= '0;
        else if (load)
            cur <= load_val;
        else if (tick_en && running) begin
            if (at_one)
                cur <= periodic ? reload_val : '0;
            else
                cur <= cur - ONE;
        end
    end

endmodule

// File: rtl/lvt_req.sv
module lvt_req
    import lvt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     fire,
    input  lvt_req_t fire_pay,
    input  logic     ready,
    output logic     valid,
    output lvt_req_t pay
);

    logic taken;
    logic slot_free;

    assign taken     = valid && ready;
    assign slot_free = !valid || ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            pay   <= '0;
        end else if (fire && slot_free) begin
            valid <= 1'b1;
            pay   <= fire_pay;
        end else if (taken) begin
            valid <= 1'b0;
        end
    end

endmodule

// File: rtl/lvt_timer.sv
module lvt_timer
    import lvt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        req_ready,
    output logic        req_valid,
    output logic [7:0]  req_vector,
    output logic [2:0]  req_mode,
    output logic        req_level
);

    lvt_entry_t       ent;
    logic [CNT_W-1:0] init_cnt;
    logic [CNT_W-1:0] init_val;
    logic [CNT_W-1:0] cur_cnt;
    logic             init_load;
    logic             expire;
    lvt_req_t         out_pay;

    lvt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .cur_cnt  (cur_cnt),
        .entry    (ent),
        .init_cnt (init_cnt),
        .init_load(init_load),
        .init_val (init_val),
        .rdata    (reg_rdata)
    );

    lvt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .load      (init_load),
        .load_val  (init_val),
        .periodic  (ent.periodic),
        .reload_val(init_cnt),
        .cur       (cur_cnt),
        .expire    (expire)
    );

    lvt_req u_req (
        .clk     (clk),
        .rst     (rst),
        .fire    (expire && !ent.masked),
        .fire_pay(entry_payload(ent)),
        .ready   (req_ready),
        .valid   (req_valid),
        .pay     (out_pay)
    );

    assign req_vector = out_pay.vector;
    assign req_mode   = out_pay.mode;
    assign req_level  = out_pay.level;

endmodule

// File: rtl/lvt_timer_chk.sv
module lvt_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic             init_load,
    input logic [CNT_W-1:0] cur_cnt,
    input logic             periodic,
    input logic             masked,
    input logic             req_ready,
    input logic             req_valid,
    input logic [7:0]       req_vector,
    input logic [2:0]       req_mode,
    input logic             req_level
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!req_valid && cur_cnt == '0));

    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !init_load && cur_cnt > CNT_W'(1)) |=> (cur_cnt == $past(cur_cnt) - CNT_W'(1)));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !init_load) |=> $stable(cur_cnt));

    // R8
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !init_load && cur_cnt == CNT_W'(1) && !periodic) |=> (cur_cnt == '0));

    // R6
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !init_load && cur_cnt == CNT_W'(1) && masked && !req_valid) |=> !req_valid);

    // R9
    hold_payload_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_vector) && $stable(req_mode) && $stable(req_level)));

    // R5
    raise_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !init_load && cur_cnt == CNT_W'(1) && !masked) |=> req_valid);

endmodule

bind lvt_timer lvt_timer_chk #(.CNT_W(CNT_W)) u_lvt_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .init_load (init_load),
    .cur_cnt   (cur_cnt),
    .periodic  (ent.periodic),
    .masked    (ent.masked),
    .req_ready (req_ready),
    .req_valid (req_valid),
    .req_vector(req_vector),
    .req_mode  (req_mode),
    .req_level (req_level)
);

// File: tb/test_lvt_timer.sv
`timescale 1ns/1ps
module test_lvt_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_ready = 1'b1;
    logic        req_valid;
    logic [7:0]  req_vector;
    logic [2:0]  req_mode;
    logic        req_level;

    always #2 clk = ~clk;

    lvt_timer i_lvt_timer (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .req_ready (req_ready),
        .req_valid (req_valid),
        .req_vector(req_vector),
        .req_mode  (req_mode),
        .req_level (req_level)
    );

    // Behavioural reference state
    logic [31:0] m_entry, m_init, m_cur;
    logic        m_pend;
    logic [7:0]  m_vec;
    logic [2:0]  m_mode;
    logic        m_lvl;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          live  = 0;
    bit          done  = 0;
    string       phase = "R1";
    int          cyc   = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_entry = 32'h0001_0000; m_init = 0; m_cur = 0; m_pend = 0;
            m_vec = 0; m_mode = 0; m_lvl = 0;
        end else begin
            bit ld, ex;
            ld = reg_wr && reg_addr == 2'd1;
            ex = tick_en && m_cur == 1 && !ld;
            if (ex && !m_entry[16] && (!m_pend || req_ready)) begin
                m_pend = 1; m_vec = m_entry[7:0]; m_mode = m_entry[10:8]; m_lvl = m_entry[15];
            end else if (m_pend && req_ready) m_pend = 0;
            if (ld) begin m_init = reg_wdata; m_cur = reg_wdata; end
            else if (tick_en && m_cur != 0)
                m_cur = (m_cur == 1) ? (m_entry[17] ? m_init : 0) : m_cur - 1;
            if (reg_wr && reg_addr == 2'd0) m_entry = reg_wdata & 32'h0003_F7FF;
        end
        live = 1;
    end

    function automatic logic [31:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return m_entry;
            2'd1: return m_init;
            2'd2: return m_cur;
            default: return 32'd0;
        endcase
    endfunction

    task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", phase, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (live && !done) begin
            cmp("req_valid", {31'd0, req_valid}, {31'd0, m_pend});
            if (m_pend) begin
                cmp("req_vector", {24'd0, req_vector}, {24'd0, m_vec});
                cmp("req_mode",   {29'd0, req_mode},   {29'd0, m_mode});
                cmp("req_level",  {31'd0, req_level},  {31'd0, m_lvl});
            end
            cmp("reg_rdata", reg_rdata, m_read(reg_addr));
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog run did not complete");
            finish_run();
        end
    end

    task automatic step(input bit t, input bit w, input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        tick_en = t; reg_wr = w; reg_addr = a; reg_wdata = d;
    endtask

    task automatic ticks(input int n, input bit alt);
        for (int i = 0; i < n; i++) step(alt ? (i % 2 == 0) : 1'b1, 1'b0, 2'd2, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        // R1: reset values
        phase = "R1";
        step(0, 0, 2'd0, 0); step(0, 0, 2'd1, 0); step(0, 0, 2'd2, 0); step(0, 0, 2'd3, 0);
        // R2: reserved bits
        phase = "R2";
        step(0, 1, 2'd0, 32'hFFFF_FFFF); step(0, 0, 2'd0, 0);
        step(0, 1, 2'd0, 32'h0000_0800); step(0, 0, 2'd0, 0);
        // R3: initial count load
        phase = "R3";
        step(0, 1, 2'd0, 32'h0000_0241); step(0, 1, 2'd1, 32'd5);
        step(0, 0, 2'd1, 0); step(0, 0, 2'd2, 0);
        // R4: alternating tick
        phase = "R4";
        ticks(4, 1);
        step(0, 0, 2'd2, 0); step(0, 0, 2'd2, 0);
        // R5: one-shot unmasked expiry
        phase = "R5";
        ticks(4, 0);
        // R8: stays at zero
        phase = "R8";
        ticks(5, 0);
        // R9: back-pressure and merge
        phase = "R9";
        req_ready = 0;
        step(0, 1, 2'd0, 32'h0000_8577); step(0, 1, 2'd1, 32'd2);
        ticks(4, 0);
        step(0, 1, 2'd0, 32'h0000_0133); step(0, 1, 2'd1, 32'd1);
        ticks(3, 0);
        req_ready = 1;
        ticks(3, 0);
        // R7: periodic reload with a stalling receiver
        phase = "R7";
        step(0, 1, 2'd0, 32'h0002_82A5); step(0, 1, 2'd1, 32'd3);
        for (int i = 0; i < 14; i++) begin req_ready = (i % 3 != 1); step(1, 0, 2'd2, 0); end
        req_ready = 1;
        ticks(3, 0);
        // R6: masked periodic, then masked one-shot
        phase = "R6";
        step(0, 1, 2'd0, 32'h0003_0033); step(0, 1, 2'd1, 32'd2);
        ticks(9, 0);
        step(0, 1, 2'd0, 32'h0001_0033); step(0, 1, 2'd1, 32'd2);
        ticks(5, 0);
        // R3: zero write stops the timer
        phase = "R3";
        step(0, 1, 2'd0, 32'h0000_0041); step(0, 1, 2'd1, 32'd4);
        ticks(2, 0);
        step(1, 1, 2'd1, 32'd0);
        ticks(5, 0);
        // R10: write on the expiry tick wins
        phase = "R10";
        step(0, 1, 2'd1, 32'd1);
        step(1, 1, 2'd1, 32'd3);
        step(0, 0, 2'd2, 0);
        ticks(5, 0);
        step(0, 0, 2'd0, 0);
        @(negedge clk);
        finish_run();
    end

endmodule